// File: doc/BRIEF.md
# Ping-Pong Receive DMA with Per-Buffer Error Tagging

This block moves received bytes out of a serial receive FIFO into memory. It uses two alternating landing buffers, A and B. Software arms a buffer by writing a start address and a byte length to it. The engine then pops one FIFO entry per cycle into the buffer whose turn it is. Each byte goes to the buffer start address plus that buffer's running byte count. When a buffer reaches its length it drops out, and the turn passes to the other buffer.

If the buffer whose turn it is has not been armed, the engine stops popping. The FIFO then fills, and the serial receiver can mark a later entry with an overrun tag. Each FIFO entry carries two tags, overrun and parity error. A tag is recorded against the buffer that takes that entry. Each buffer keeps its own sticky flags. Re-arming that buffer clears them, and so does a soft reset of the engine.

Top module: `pp_rx_dma`

## Requirements
- R1: After reset all status bits (active, overrun, parity) are 0. No FIFO pop and no memory write occur, and buffer A has the first turn.
- R2: While the buffer whose turn it is is not active, `fifo_pop` stays 0 and the FIFO entries are left in place.
- R3: After a buffer completes, the next byte goes only to the other buffer. This holds even if the completed buffer has been re-armed and the other buffer has not.
- R4: A load with a nonzero length sets that buffer's active bit from the next cycle and restarts its count at zero. It clears that buffer's overrun and parity flags. A load to a buffer that is already active restarts it at the new address.
- R5: A buffer's active bit clears in the cycle after it takes its programmed number of bytes.
- R6: Each pop causes exactly one memory write in the same cycle. The write data is the FIFO byte and the write address is (start + count) modulo 2^13.
- R7: If both buffers are armed, the handoff from one to the other loses no cycle. The first byte of the second buffer is written in the cycle right after the last byte of the first.
- R8: An entry with the overrun tag sets the overrun flag of the buffer that takes it, and only that buffer's flag. The flag stays set until that buffer is reloaded or a soft reset occurs.
- R9: An entry with the parity tag sets the parity flag of the buffer that takes it, and only that buffer's flag. The flag stays set until that buffer is reloaded or a soft reset occurs.
- R10: A load with length 0 leaves that buffer inactive.
- R11: A soft reset clears every status bit and returns the turn to buffer A. No pop occurs in that cycle.
- R12: A load to the buffer whose turn it is holds off the pop in that cycle. The pending byte then lands at the new start address.

Status vectors use bit 0 for buffer A and bit 1 for buffer B. `ld_sel` = 0 selects A and `ld_sel` = 1 selects B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset of the receive engine |
| ld_valid | input | 1 | Load strobe for one buffer |
| ld_sel | input | 1 | Buffer to load (0 = A, 1 = B) |
| ld_addr | input | 13 | Buffer start address |
| ld_len | input | 13 | Buffer length in bytes |
| fifo_valid | input | 1 | FIFO holds at least one entry |
| fifo_data | input | 8 | FIFO head byte |
| fifo_perr | input | 1 | Parity tag of the head entry |
| fifo_ovr | input | 1 | Overrun tag of the head entry |
| fifo_pop | output | 1 | Pop the head entry this cycle |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 13 | Memory write address |
| mem_data | output | 8 | Memory write data |
| buf_active | output | 2 | Active bits (bit 0 = A, bit 1 = B) |
| buf_ovr | output | 2 | Overrun flags |
| buf_perr | output | 2 | Parity flags |

## Verification
A memory write appears combinationally in the same cycle as its pop. A status bit changes one clock edge after the load, pop or soft reset that causes it. The bench drives inputs one nanosecond after a rising edge. It samples writes and status at the following falling edge, so each status check waits exactly one edge past its stimulus. Expected writes are queued by the driver in the order the turn rules predict. The handoff check compares the cycle stamps of consecutive writes, so a one-cycle bubble is caught.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    localparam int RXDMA_ADDR_W = 13;
    localparam int RXDMA_LEN_W  = 13;
    localparam int RXDMA_DATA_W = 8;
    localparam int RXDMA_NBUF   = 2;
endpackage

// File: rtl/rxdma_buf.sv
module rxdma_buf #(
    parameter int AW = rxdma_pkg::RXDMA_ADDR_W,
    parameter int LW = rxdma_pkg::RXDMA_LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [LW-1:0] ld_len,
    input  logic          take,
    input  logic          tag_ovr,
    input  logic          tag_perr,
    output logic          active,
    output logic          ovr,
    output logic          perr,
    output logic          last,
    output logic [AW-1:0] wr_addr
);
    typedef struct packed {
        logic          active;
        logic [AW-1:0] start;
        logic [LW-1:0] len;
        logic [LW-1:0] cnt;
        logic          ovr;
        logic          perr;
    } bstate_t;

    bstate_t s_q, s_d;
    logic [LW-1:0] cnt_inc;

    always_comb begin
        cnt_inc = s_q.cnt + 1'b1;
        last    = s_q.active && (cnt_inc == s_q.len);
        wr_addr = s_q.start + AW'(s_q.cnt);
        s_d     = s_q;
        if (soft_rst) begin
            s_d = '0;
        end else if (ld_en) begin
            s_d.active = (ld_len != '0);
            s_d.start  = ld_addr;
            s_d.len    = ld_len;
            s_d.cnt    = '0;
            s_d.ovr    = 1'b0;
            s_d.perr   = 1'b0;
        end else if (take) begin
            s_d.cnt  = cnt_inc;
            s_d.ovr  = s_q.ovr | tag_ovr;
            s_d.perr = s_q.perr | tag_perr;
            if (last) begin
                s_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active = s_q.active;
    assign ovr    = s_q.ovr;
    assign perr   = s_q.perr;

    // R4
    load_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !soft_rst && ld_len != '0) |=> (active && s_q.cnt == '0 && !ovr && !perr));
    // R10
    zero_len_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !soft_rst && ld_len == '0) |=> !active);
    // R2
    take_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> active);
    // R5
    done_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last && !ld_en && !soft_rst) |=> !active);
    // R8
    ovr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && tag_ovr && !ld_en && !soft_rst) |=> ovr);
    // R9
    perr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && tag_perr && !ld_en && !soft_rst) |=> perr);
    // R11
    soft_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!active && !ovr && !perr));
endmodule

// File: rtl/rxdma_seq.sv
module rxdma_seq #(
    parameter int NBUF = rxdma_pkg::RXDMA_NBUF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            fifo_valid,
    input  logic [NBUF-1:0] ld_en,
    input  logic [NBUF-1:0] active,
    input  logic [NBUF-1:0] last,
    output logic            pop,
    output logic            turn,
    output logic [NBUF-1:0] take
);
    typedef struct packed {
        logic turn;
    } sstate_t;

    sstate_t s_q, s_d;

    always_comb begin
        pop = fifo_valid && active[s_q.turn] && !soft_rst && !ld_en[s_q.turn];
        s_d = s_q;
        if (soft_rst) begin
            s_d.turn = 1'b0;
        end else if (pop && last[s_q.turn]) begin
            s_d.turn = ~s_q.turn;
        end
    end

    for (genvar i = 0; i < NBUF; i++) begin : g_take
        assign take[i] = pop && (s_q.turn == 1'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign turn = s_q.turn;

    // R3
    flip_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && last[turn] && !soft_rst) |=> (turn != $past(turn)));
    // R3
    hold_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !(pop && last[turn])) |=> $stable(turn));
    // R6
    single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));
    // R2
    idle_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active[turn] |-> !pop);
    // R11
    soft_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (turn == 1'b0));
endmodule

// File: rtl/pp_rx_dma.sv
module pp_rx_dma #(
    parameter int AW = rxdma_pkg::RXDMA_ADDR_W,
    parameter int LW = rxdma_pkg::RXDMA_LEN_W,
    parameter int DW = rxdma_pkg::RXDMA_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          ld_valid,
    input  logic          ld_sel,
    input  logic [AW-1:0] ld_addr,
    input  logic [LW-1:0] ld_len,
    input  logic          fifo_valid,
    input  logic [DW-1:0] fifo_data,
    input  logic          fifo_perr,
    input  logic          fifo_ovr,
    output logic          fifo_pop,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    output logic [1:0]    buf_active,
    output logic [1:0]    buf_ovr,
    output logic [1:0]    buf_perr
);
    localparam int NBUF = 2;

    logic [NBUF-1:0] ld_en;
    logic [NBUF-1:0] take;
    logic [NBUF-1:0] last;
    logic [AW-1:0]   wr_addr [NBUF];
    logic            pop;
    logic            turn;

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        assign ld_en[i] = ld_valid && (ld_sel == 1'(i));
        rxdma_buf #(.AW(AW), .LW(LW)) u_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .ld_en    (ld_en[i]),
            .ld_addr  (ld_addr),
            .ld_len   (ld_len),
            .take     (take[i]),
            .tag_ovr  (fifo_ovr),
            .tag_perr (fifo_perr),
            .active   (buf_active[i]),
            .ovr      (buf_ovr[i]),
            .perr     (buf_perr[i]),
            .last     (last[i]),
            .wr_addr  (wr_addr[i])
        );
    end

    rxdma_seq #(.NBUF(NBUF)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .fifo_valid (fifo_valid),
        .ld_en      (ld_en),
        .active     (buf_active),
        .last       (last),
        .pop        (pop),
        .turn       (turn),
        .take       (take)
    );

    assign fifo_pop = pop;
    assign mem_we   = pop;
    assign mem_addr = wr_addr[turn];
    assign mem_data = fifo_data;

    // R12
    load_holds_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_sel == turn) |-> !fifo_pop);
    // R6
    write_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> fifo_valid);
endmodule

// File: tb/pp_rx_dma_bench.sv
`timescale 1ns/1ps
module pp_rx_dma_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        ld_valid = 1'b0;
    logic        ld_sel = 1'b0;
    logic [12:0] ld_addr = '0;
    logic [12:0] ld_len = '0;
    logic        fifo_valid;
    logic [7:0]  fifo_data;
    logic        fifo_perr;
    logic        fifo_ovr;
    logic        fifo_pop;
    logic        mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_data;
    logic [1:0]  buf_active;
    logic [1:0]  buf_ovr;
    logic [1:0]  buf_perr;

    always #2.5 clk = ~clk;

    pp_rx_dma u_pp_rx_dma (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_len(ld_len),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_perr(fifo_perr),
        .fifo_ovr(fifo_ovr), .fifo_pop(fifo_pop),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .buf_active(buf_active), .buf_ovr(buf_ovr), .buf_perr(buf_perr)
    );

    // FIFO model: entry = {ovr, perr, data}
    logic [9:0] fmem [16];
    int wp = 0;
    int rp = 0;
    assign fifo_valid = (wp != rp);
    assign {fifo_ovr, fifo_perr, fifo_data} = fmem[rp & 15];
    always @(posedge clk) if (fifo_pop) rp <= rp + 1;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int nwr = 0;
    int stamp [64];
    logic [20:0] exp_q [$];
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard monitor (R6)
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R6 unexpected write: actual addr=%h data=%h expected none", mem_addr, mem_data);
            end else begin
                if ({mem_addr, mem_data} !== exp_q[0]) begin
                    errors++;
                    $display("FAIL R6 write: actual addr=%h data=%h expected addr=%h data=%h",
                             mem_addr, mem_data, exp_q[0][20:8], exp_q[0][7:0]);
                end
                void'(exp_q.pop_front());
            end
            if (nwr < 64) stamp[nwr] = cyc;
            nwr++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle(input int n);
        repeat (n) tick();
    endtask

    task automatic push(input logic [7:0] d, input logic perr, input logic ovr);
        fmem[wp & 15] = {ovr, perr, d};
        wp++;
    endtask

    task automatic expect_wr(input logic [12:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic load(input logic sel, input logic [12:0] a, input logic [12:0] len);
        ld_valid = 1'b1;
        ld_sel   = sel;
        ld_addr  = a;
        ld_len   = len;
        tick();
        ld_valid = 1'b0;
    endtask

    task automatic chk(input string tag, input int act, input int expv);
        @(negedge clk);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
        tick();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) fmem[i] = '0;
        settle(3);
        rst_n = 1'b1;
        tick();

        // R1: reset state, R2: no pop while A unarmed
        push(8'h11, 1'b0, 1'b0);
        push(8'h22, 1'b0, 1'b0);
        settle(3);
        @(negedge clk);
        checks++;
        if (fifo_pop !== 1'b0 || mem_we !== 1'b0) begin
            errors++;
            $display("FAIL R1 pop/we: actual=%b%b expected=00", fifo_pop, mem_we);
        end
        tick();
        chk("R1 active", buf_active, 0);
        chk("R1 ovr", buf_ovr, 0);
        chk("R1 perr", buf_perr, 0);
        chk("R2 fifo level", wp - rp, 2);

        // R7 R5 R6: A then B back to back
        expect_wr(13'h100, 8'h11); expect_wr(13'h101, 8'h22); expect_wr(13'h102, 8'h33);
        expect_wr(13'h200, 8'h44); expect_wr(13'h201, 8'h55);
        push(8'h33, 1'b0, 1'b0);
        push(8'h44, 1'b0, 1'b0);
        push(8'h55, 1'b0, 1'b0);
        load(1'b0, 13'h100, 13'd3);
        load(1'b1, 13'h200, 13'd2);
        settle(6);
        chk("R6 all written", exp_q.size(), 0);
        chk("R7 handoff gap", stamp[4] - stamp[0], 4);
        chk("R5 both idle", buf_active, 0);

        // R3: strict alternation (turn now A)
        expect_wr(13'h300, 8'h66);
        load(1'b0, 13'h300, 13'd1);
        push(8'h66, 1'b0, 1'b0);
        settle(3);
        load(1'b0, 13'h340, 13'd1);
        push(8'h77, 1'b0, 1'b0);
        settle(3);
        chk("R3 byte held for B", wp - rp, 1);
        chk("R3 A armed", buf_active, 1);
        expect_wr(13'h400, 8'h77);
        expect_wr(13'h340, 8'h88);
        load(1'b1, 13'h400, 13'd1);
        push(8'h88, 1'b0, 1'b0);
        settle(4);
        chk("R3 order", exp_q.size(), 0);

        // R8 R9 R4: tags (turn now B)
        expect_wr(13'h500, 8'h99); expect_wr(13'h501, 8'hAA);
        load(1'b1, 13'h500, 13'd2);
        push(8'h99, 1'b0, 1'b1);
        push(8'hAA, 1'b0, 1'b0);
        settle(4);
        chk("R8 ovr on B", buf_ovr, 2);
        chk("R9 no perr", buf_perr, 0);
        expect_wr(13'h600, 8'hBB);
        load(1'b0, 13'h600, 13'd1);
        push(8'hBB, 1'b1, 1'b0);
        settle(3);
        chk("R9 perr on A", buf_perr, 1);
        chk("R8 ovr sticky", buf_ovr, 2);
        load(1'b1, 13'h700, 13'd4);
        @(negedge clk);
        checks++;
        if (buf_ovr !== 2'b00 || buf_active !== 2'b10 || buf_perr !== 2'b01) begin
            errors++;
            $display("FAIL R4 reload clear: actual ovr=%b act=%b perr=%b expected 00 10 01",
                     buf_ovr, buf_active, buf_perr);
        end
        tick();

        // R4 restart of active buffer
        expect_wr(13'h700, 8'hCC);
        push(8'hCC, 1'b0, 1'b0);
        settle(2);
        expect_wr(13'h780, 8'hDD);
        load(1'b1, 13'h780, 13'd1);
        push(8'hDD, 1'b0, 1'b0);
        settle(3);
        chk("R4 restart", exp_q.size(), 0);

        // R12: load to buffer in turn while a byte waits (turn now A)
        load(1'b0, 13'h800, 13'd2);
        expect_wr(13'h900, 8'hEE);
        expect_wr(13'h901, 8'hF0);
        push(8'hEE, 1'b0, 1'b0);
        load(1'b0, 13'h900, 13'd2);
        push(8'hF0, 1'b0, 1'b0);
        settle(4);
        chk("R12 held pop", exp_q.size(), 0);

        // R10: zero-length load (turn now B)
        load(1'b1, 13'h050, 13'd0);
        chk("R10 inactive", buf_active, 0);
        push(8'h12, 1'b0, 1'b0);
        settle(2);
        chk("R10 no pop", wp - rp, 1);

        // R11: soft reset, then turn back at A; R6 address wrap
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        chk("R11 flags", {buf_active, buf_ovr, buf_perr}, 0);
        expect_wr(13'h1FFF, 8'h12);
        expect_wr(13'h0000, 8'h34);
        load(1'b0, 13'h1FFF, 13'd2);
        push(8'h34, 1'b0, 1'b0);
        settle(4);
        chk("R11 R6 wrap", exp_q.size(), 0);
        chk("R5 final idle", buf_active, 0);

        summary();
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end
endmodule